// File: doc/BRIEF.md
# Four-Phase Handshake Clock-Domain Word Bridge

This block moves single data words from a sending clock domain to an unrelated receiving clock domain. A request/acknowledge pair runs a return-to-zero handshake across the boundary, and each direction passes through its own multi-flop synchronizer. The sender presents a word together with a valid level. The block latches the word and raises the request. Once the receiver has captured the word and its acknowledge has come back, the block pulses a sent indication.

On the receiving side, the synchronized request is held off until a ready input is high. The word is then captured, a one-cycle valid pulse is issued and the acknowledge is raised. The sender clears its request as soon as the synchronized acknowledge appears. The receiver drops the acknowledge as soon as the synchronized request falls, with no extra state step. These two shortcuts make the full round trip shorter than a plain two-flop handshake. The source must keep the valid level and the word steady until it sees the sent pulse, and may present the next word in the cycle after it.

Top module: `hs4_sync`

## Requirements
- R1: While either reset is low, and right after it, `snt_o` and `vo_o` are 0 and `data_o` is all zeros.
- R2: Every word accepted on the sending side appears on `data_o` exactly once, in the order it was accepted, whatever the ratio of the two clock periods.
- R3: `vo_o` is high for exactly one receive cycle for each delivered word, and `data_o` carries that word in that cycle.
- R4: `snt_o` is high for exactly one send cycle for each word, and only after the receiver has captured that word.
- R5: While `ready_i` is low, no word is captured and `vo_o` stays 0. A pending word is delivered after `ready_i` returns high.
- R6: `data_o` changes only in a cycle where `vo_o` is high and holds its value between pulses.
- R7: When idle, the sender takes `data_i` at the first send clock edge that sees `vi_i` high. Changes on `data_i` or `vi_i` after that edge and before `snt_o` have no effect on the delivered word.
- R8: With `vi_i` held low, no `snt_o` and no `vo_o` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk_i | input | 1 | Sending-domain clock |
| tx_rst_ni | input | 1 | Sending-domain asynchronous reset, active low |
| vi_i | input | 1 | Word on `data_i` is valid; held until `snt_o` |
| data_i | input | WIDTH | Word to transfer |
| snt_o | output | 1 | One-cycle pulse: word acknowledged by receiver |
| rx_clk_i | input | 1 | Receiving-domain clock |
| rx_rst_ni | input | 1 | Receiving-domain asynchronous reset, active low |
| ready_i | input | 1 | Receiver can accept a word |
| data_o | output | WIDTH | Last received word |
| vo_o | output | 1 | One-cycle pulse: new word on `data_o` |

## Verification
A sender FSM stuck in its wait state shows at the ports as a missing `snt_o` and a stalled source within a few tens of cycles. A sender that re-enters acceptance too early shows as a duplicate word on `data_o` on the next handshake. A receiver that captures without ready, or whose acknowledge is out of step with the request, shows as a `vo_o` pulse during a ready-low window, a lost or doubled word, or a changed `data_o` without a pulse. Each of these shows within one round trip of the handshake. Scoreboard ordering across three clock ratios and a long ready-low stall catch these faults.

// File: rtl/hs4_sync_pkg.sv
`timescale 1ns/1ps
package hs4_sync_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WACK = 2'd1,
    TX_DONE = 2'd2
  } tx_state_e;
endpackage

// File: rtl/hs4_sync_cdc.sv
`timescale 1ns/1ps
module hs4_sync_cdc #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  // plain flop chain: nothing between stages
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs4_sync_tx.sv
`timescale 1ns/1ps
module hs4_sync_tx
  import hs4_sync_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vi_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [WIDTH-1:0] data_o,
  output logic             snt_o
);
  tx_state_e        state_q;
  logic             ack_s;
  logic             req_q;
  logic             snt_q;
  logic             load;
  logic [WIDTH-1:0] word_q;

  hs4_sync_cdc #(.STAGES(STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  // DONE may reload directly once the acknowledge has gone low
  always_comb begin
    load = 1'b0;
    unique case (state_q)
      TX_IDLE: load = vi_i & ~ack_s;
      TX_DONE: load = vi_i & ~ack_s;
      default: load = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      req_q   <= 1'b0;
      snt_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      snt_q <= 1'b0;
      if (load) begin
        word_q  <= data_i;
        req_q   <= 1'b1;
        state_q <= TX_WACK;
      end else begin
        unique case (state_q)
          TX_WACK: if (ack_s) begin
            req_q   <= 1'b0;
            snt_q   <= 1'b1;
            state_q <= TX_DONE;
          end
          TX_DONE: if (!ack_s) state_q <= TX_IDLE;
          default: state_q <= state_q;
        endcase
      end
    end
  end

  // sampled acknowledge withdraws the request without waiting for an edge
  assign req_o  = req_q & ~ack_s;
  assign data_o = word_q;
  assign snt_o  = snt_q;
endmodule

// File: rtl/hs4_sync_rx.sv
`timescale 1ns/1ps
module hs4_sync_rx #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             ready_i,
  output logic             ack_o,
  output logic [WIDTH-1:0] data_o,
  output logic             vo_o
);
  logic             req_s;
  logic             ack_q;
  logic             vo_q;
  logic             capture;
  logic [WIDTH-1:0] data_q;

  hs4_sync_cdc #(.STAGES(STAGES)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  assign capture = req_s & ~ack_q & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      vo_q   <= 1'b0;
      data_q <= '0;
    end else begin
      vo_q <= capture;
      if (capture) data_q <= data_i;
      if (!req_s)       ack_q <= 1'b0;
      else if (capture) ack_q <= 1'b1;
    end
  end

  // falling synchronized request drops the acknowledge at once
  assign ack_o  = ack_q & req_s;
  assign data_o = data_q;
  assign vo_o   = vo_q;
endmodule

// File: rtl/hs4_sync.sv
`timescale 1ns/1ps
module hs4_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             tx_clk_i,
  input  logic             tx_rst_ni,
  input  logic             vi_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             snt_o,
  input  logic             rx_clk_i,
  input  logic             rx_rst_ni,
  input  logic             ready_i,
  output logic [WIDTH-1:0] data_o,
  output logic             vo_o
);
  logic             req;
  logic             ack;
  logic [WIDTH-1:0] tx_word;

  hs4_sync_tx #(.WIDTH(WIDTH), .STAGES(STAGES)) u_tx (
    .clk_i (tx_clk_i),
    .rst_ni(tx_rst_ni),
    .vi_i  (vi_i),
    .data_i(data_i),
    .ack_i (ack),
    .req_o (req),
    .data_o(tx_word),
    .snt_o (snt_o)
  );

  hs4_sync_rx #(.WIDTH(WIDTH), .STAGES(STAGES)) u_rx (
    .clk_i  (rx_clk_i),
    .rst_ni (rx_rst_ni),
    .req_i  (req),
    .data_i (tx_word),
    .ready_i(ready_i),
    .ack_o  (ack),
    .data_o (data_o),
    .vo_o   (vo_o)
  );
endmodule

// File: rtl/hs4_sync_chk.sv
`timescale 1ns/1ps
module hs4_sync_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             tx_clk_i,
  input logic             tx_rst_ni,
  input logic             snt_o,
  input logic             rx_clk_i,
  input logic             rx_rst_ni,
  input logic             ready_i,
  input logic [WIDTH-1:0] data_o,
  input logic             vo_o,
  input logic             req,
  input logic             ack,
  input logic [WIDTH-1:0] tx_word
);
  assert_vo_pulse_R3: assert property (@(posedge rx_clk_i) disable iff (!rx_rst_ni)
    vo_o |=> !vo_o);

  assert_snt_pulse_R4: assert property (@(posedge tx_clk_i) disable iff (!tx_rst_ni)
    snt_o |=> !snt_o);

  assert_snt_after_req_drop_R4: assert property (@(posedge tx_clk_i) disable iff (!tx_rst_ni)
    snt_o |-> !$past(req));

  assert_vo_needs_ready_R5: assert property (@(posedge rx_clk_i) disable iff (!rx_rst_ni)
    $rose(vo_o) |-> $past(ready_i));

  assert_ack_with_vo_R3: assert property (@(posedge rx_clk_i) disable iff (!rx_rst_ni)
    $rose(ack) |-> vo_o);

  assert_data_hold_R6: assert property (@(posedge rx_clk_i) disable iff (!rx_rst_ni)
    !vo_o |-> $stable(data_o));

  assert_word_stable_R7: assert property (@(posedge tx_clk_i) disable iff (!tx_rst_ni)
    (req && $past(req)) |-> $stable(tx_word));
endmodule

bind hs4_sync hs4_sync_chk #(.WIDTH(WIDTH)) u_chk (
  .tx_clk_i (tx_clk_i),
  .tx_rst_ni(tx_rst_ni),
  .snt_o    (snt_o),
  .rx_clk_i (rx_clk_i),
  .rx_rst_ni(rx_rst_ni),
  .ready_i  (ready_i),
  .data_o   (data_o),
  .vo_o     (vo_o),
  .req      (req),
  .ack      (ack),
  .tx_word  (tx_word)
);

// File: tb/hs4_sync_bench.sv
`timescale 1ns/1ps
module hs4_sync_bench;
  localparam int W = 16;

  logic         tx_clk = 1'b0;
  logic         rx_clk = 1'b0;
  logic         tx_rst_n = 1'b0;
  logic         rx_rst_n = 1'b0;
  logic         vi = 1'b0;
  logic [W-1:0] din = '0;
  logic         ready = 1'b1;
  logic         snt;
  logic [W-1:0] dout;
  logic         vo;

  realtime rx_half = 13.7;
  int checks = 0;
  int errors = 0;
  int tx_cnt = 0;
  int rx_cnt = 0;
  bit mon_on = 1'b0;
  bit hold_low = 1'b0;
  bit rand_ready = 1'b0;
  bit prev_vo = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] last_data = '0;
  logic [W-1:0] exp_q[$];

  hs4_sync #(.WIDTH(W), .STAGES(2)) u_hs4_sync (
    .tx_clk_i (tx_clk),
    .tx_rst_ni(tx_rst_n),
    .vi_i     (vi),
    .data_i   (din),
    .snt_o    (snt),
    .rx_clk_i (rx_clk),
    .rx_rst_ni(rx_rst_n),
    .ready_i  (ready),
    .data_o   (dout),
    .vo_o     (vo)
  );

  always #10 tx_clk = ~tx_clk;
  always begin
    #(rx_half) rx_clk = ~rx_clk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] next_word(input int i);
    return W'((i * 16'h3a7) ^ 16'h5c00) ^ W'($urandom);
  endfunction

  // receive-side scoreboard
  always @(negedge rx_clk) begin
    if (rand_ready) ready = ($urandom % 4) != 0;
    if (mon_on) begin
      if (vo) begin
        chk(!prev_vo, "R3 vo width", 32'(prev_vo), 0);
        chk(!hold_low, "R5 vo while not ready", 1, 0);
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected word", 32'(dout), 0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(dout == e, "R2 word order", 32'(dout), 32'(e));
        end
        last_data = dout;
        rx_cnt++;
      end else begin
        chk(dout == last_data, "R6 data hold", 32'(dout), 32'(last_data));
      end
      prev_vo = vo;
    end
  end

  task automatic wait_snt(input string tag);
    int n = 0;
    while (!snt && n < 5000) begin
      @(negedge tx_clk);
      n++;
    end
    chk(snt, tag, 32'(snt), 1);
    chk(rx_cnt >= tx_cnt + 1, "R4 snt after capture", 32'(rx_cnt), 32'(tx_cnt + 1));
    tx_cnt++;
  endtask

  task automatic send(input logic [W-1:0] w);
    @(negedge tx_clk);
    vi = 1'b1;
    din = w;
    exp_q.push_back(w);
    @(negedge tx_clk);
    wait_snt("R4 snt seen");
    vi = 1'b0;
    din = W'($urandom);
    @(negedge tx_clk);
    chk(!snt, "R4 snt width", 32'(snt), 0);
  endtask

  initial begin
    void'($urandom(32'd7));
    // R1 reset state
    repeat (4) @(negedge tx_clk);
    chk(!snt, "R1 snt in reset", 32'(snt), 0);
    chk(!vo, "R1 vo in reset", 32'(vo), 0);
    chk(dout == '0, "R1 data in reset", 32'(dout), 0);
    tx_rst_n = 1'b1;
    rx_rst_n = 1'b1;
    repeat (3) @(negedge tx_clk);
    chk(!snt && !vo && dout == '0, "R1 after reset", {snt, vo, 14'd0, dout}, 0);
    mon_on = 1'b1;

    // R8 idle: nothing moves
    repeat (40) @(negedge tx_clk);
    chk(tx_cnt == 0 && rx_cnt == 0 && !snt, "R8 idle", 32'(rx_cnt), 0);

    // R7 one-cycle valid, then garbage on data_i
    @(negedge tx_clk);
    vi = 1'b1;
    din = 16'hbeef;
    exp_q.push_back(16'hbeef);
    @(negedge tx_clk);
    vi = 1'b0;
    din = 16'h1234;
    wait_snt("R7 snt seen");
    repeat (20) @(negedge tx_clk);
    chk(last_data == 16'hbeef, "R7 captured word", 32'(last_data), 32'hbeef);

    // R5 ready held low with a word pending
    @(negedge rx_clk);
    ready = 1'b0;
    hold_low = 1'b1;
    repeat (3) @(negedge rx_clk);
    fork
      send(16'h0f0f);
      begin
        repeat (60) @(negedge rx_clk);
        chk(rx_cnt == 1, "R5 stalled", 32'(rx_cnt), 1);
        hold_low = 1'b0;
        ready = 1'b1;
      end
    join
    chk(rx_cnt == 2, "R5 delivered after ready", 32'(rx_cnt), 2);

    // R2 random traffic at three clock ratios
    rand_ready = 1'b1;
    for (int ph = 0; ph < 3; ph++) begin
      rx_half = (ph == 0) ? 13.7 : (ph == 1) ? 4.1 : 30.3;
      for (int i = 0; i < 20; i++) begin
        repeat ($urandom % 4) @(negedge tx_clk);
        send(next_word(i + 20 * ph));
      end
    end
    rand_ready = 1'b0;
    ready = 1'b1;

    // R8 idle after traffic
    repeat (60) @(negedge tx_clk);
    chk(rx_cnt == tx_cnt, "R2 counts match", 32'(rx_cnt), 32'(tx_cnt));
    chk(exp_q.size() == 0, "R2 nothing lost", 32'(exp_q.size()), 0);
    chk(!snt && !vo, "R8 quiet", {30'd0, snt, vo}, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      chk(1'b0, "R2 watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule